// File: doc/BRIEF.md
# Serial Transmitter with Programmable Bit Clock

This block turns bytes into asynchronous serial frames on a single output line. A 16-bit divisor, supplied as separate high and low bytes, sets how many system clocks make up one bit-clock period. Every serial bit is held for sixteen bit-clock periods. The line format comes from a set of control inputs that are captured when each frame begins. These inputs select the data length (5 to 8 bits), whether a parity bit is present, its sense or a forced constant value, and the stop length.

A one-entry holding register accepts a byte from the host side. The byte moves into the serializer on a bit-clock tick once the line is free. When automatic flow control is enabled, that move also waits for the clear-to-send input. Two status outputs report an empty holding register and a fully idle transmitter. A break input pulls the line low for as long as it is held. A zero divisor stops the bit clock and parks the line high.

Top module: `uart_tx_core`

## Requirements
- R1: The divisor is {div_hi_i, div_lo_i}. With a non-zero divisor D, a bit-clock tick occurs every D system clocks. A frame starts only on a tick, and each serial bit lasts 16 ticks (16·D clocks).
- R2: A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then the stop bits. The data length comes from wlen_i: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Unused high data bits are not sent.
- R3: When par_en_i is 1, one parity bit follows the data and covers only the sent data bits. par_even_i = 1 makes the count of ones in data plus parity even, and 0 makes it odd. With par_stick_i = 1 the parity bit is instead the constant inverse of par_even_i.
- R4: With stop2_i = 0 the stop level lasts 16 ticks. With stop2_i = 1 it lasts 24 ticks for 5-bit data and 32 ticks for any other length.
- R5: A divisor of 0 produces no ticks. No frame starts, a written byte stays in the holding register, and tx_o stays high unless break is set.
- R6: While brk_i is 1, tx_o is 0. The frame timing continues underneath, and the line shows the frame again once brk_i drops.
- R7: With afc_en_i = 1, a frame starts only on a tick where cts_i is 1. A frame already started runs to its end even if cts_i falls.
- R8: A write with wr_i = 1 fills the holding register, and hold_empty_o falls on the next cycle. The flag rises on the edge where the byte moves to the serializer. A write that arrives while the register is full and not being emptied on that edge is dropped.
- R9: The line-format inputs are sampled when a frame starts, so changes during a frame do not alter it. tx_empty_o is 1 only when the holding register is empty and no frame is in progress.
- R10: After reset, tx_o is 1 and both hold_empty_o and tx_empty_o are 1.
- R11: If the holding register is full and the start conditions hold, the next start bit follows the last stop tick directly, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_hi_i | input | 8 | Divisor high byte |
| div_lo_i | input | 8 | Divisor low byte |
| wlen_i | input | 2 | Data length code (0..3 = 5..8 bits) |
| stop2_i | input | 1 | Long stop setting |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Forced parity value |
| brk_i | input | 1 | Force line low |
| afc_en_i | input | 1 | Automatic flow control enable |
| cts_i | input | 1 | Clear to send |
| wr_i | input | 1 | Write strobe for holding register |
| wdata_i | input | 8 | Byte to send |
| tx_o | output | 1 | Serial output line |
| hold_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding register and serializer both idle |

## Verification
If the tick counter is off by one, tx_o edges drift away from the expected 16·D grid. That shows up within the first bit of a frame. A wrong frame length or stop length moves the next start edge, or the rise of tx_empty_o, by at least one tick. A wrong captured format or parity bit makes tx_o differ inside the frame where it occurs. Because the reference line is compared on every clock, each of these is caught in the cycle it first appears. Flag-handling faults are exposed within a cycle of the write or transfer edge. That includes a dropped write that is not dropped, or a cts gate that is ignored.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVS = 16;

  typedef enum logic [1:0] {
    WLEN5 = 2'd0,
    WLEN6 = 2'd1,
    WLEN7 = 2'd2,
    WLEN8 = 2'd3
  } wlen_e;

  typedef struct packed {
    wlen_e wlen;
    logic  stop2;
    logic  par_en;
    logic  par_even;
    logic  par_stick;
  } line_cfg_t;
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             div_zero, wrap;

  assign div_zero = (div_i == '0);
  // >= so a shrinking divisor never strands the counter
  assign wrap     = !div_zero && (cnt_q >= div_i - DIV_W'(1));
  assign tick_o   = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (div_zero || wrap) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (div_i > DIV_W'(1)) |=> !tick_o || !$stable(div_i));
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = wr_i && (!full_q || take_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= wdata_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  assert_drop_when_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && wr_i && !take_i |=> full_q && $stable(data_q));

  assert_take_needs_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int TCNT_W  = 8
) (
  input  logic [DATA_W-1:0]  data_i,
  input  line_cfg_t          cfg_i,
  output logic [FRAME_W-1:0] bits_o,
  output logic [TCNT_W-1:0]  last_tick_o
);
  localparam int MIN_W = DATA_W - 3;

  logic [DATA_W-1:0] keep;
  logic [3:0]        nbits;
  logic              par_raw, par_bit;

  for (genvar g = 0; g < DATA_W; g++) begin : g_keep
    assign keep[g] = (g < MIN_W) || (int'(cfg_i.wlen) >= g - MIN_W + 1);
  end

  assign nbits   = 4'(MIN_W) + {2'b00, cfg_i.wlen};
  assign par_raw = ^(data_i & keep);
  assign par_bit = cfg_i.par_stick ? ~cfg_i.par_even
                                   : (cfg_i.par_even ? par_raw : ~par_raw);

  always_comb begin
    bits_o    = '1;
    bits_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (keep[i]) bits_o[i+1] = data_i[i];
    if (cfg_i.par_en) bits_o[int'(nbits)+1] = par_bit;
  end

  always_comb begin : calc
    int body_t;
    int stop_t;
    body_t = OVS * (1 + int'(nbits) + int'(cfg_i.par_en));
    if (!cfg_i.stop2)              stop_t = OVS;
    else if (cfg_i.wlen == WLEN5)  stop_t = OVS + OVS / 2;
    else                           stop_t = 2 * OVS;
    last_tick_o = TCNT_W'(body_t + stop_t - 1);
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int TCNT_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               start_ok_i,
  input  logic [FRAME_W-1:0] bits_i,
  input  logic [TCNT_W-1:0]  last_tick_i,
  output logic               take_o,
  output logic               busy_o,
  output logic               line_o
);
  localparam int SUB_W = $clog2(OVS);

  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [TCNT_W-1:0]  tcnt_q, last_q;
  logic               done, free;

  assign done   = busy_q && (tcnt_q == last_q);
  assign free   = !busy_q || done;
  assign take_o = tick_i && free && start_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      tcnt_q <= '0;
      last_q <= '0;
    end else if (tick_i) begin
      if (take_o) begin
        busy_q <= 1'b1;
        sh_q   <= bits_i;
        tcnt_q <= '0;
        last_q <= last_tick_i;
      end else if (done) begin
        busy_q <= 1'b0;
        sh_q   <= '1;
      end else if (busy_q) begin
        tcnt_q <= tcnt_q + TCNT_W'(1);
        if (tcnt_q[SUB_W-1:0] == '1) sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
      end
    end
  end

  assign busy_o = busy_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;

  assert_start_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_ok_i) && $past(tick_i));

  assert_frame_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> tcnt_q <= last_q);
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        div_hi_i,
  input  logic [7:0]        div_lo_i,
  input  logic [1:0]        wlen_i,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_stick_i,
  input  logic              brk_i,
  input  logic              afc_en_i,
  input  logic              cts_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              tx_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o
);
  localparam int DIV_W   = 16;
  localparam int FRAME_W = DATA_W + 4;
  localparam int TCNT_W  = $clog2(OVS * FRAME_W + 1);

  logic [DIV_W-1:0]   div;
  line_cfg_t          cfg;
  logic               tick, hold_full, take, busy, line, start_ok;
  logic [DATA_W-1:0]  hold_data;
  logic [FRAME_W-1:0] frame_bits;
  logic [TCNT_W-1:0]  last_tick;

  assign div = {div_hi_i, div_lo_i};
  assign cfg = '{wlen: wlen_e'(wlen_i), stop2: stop2_i, par_en: par_en_i,
                 par_even: par_even_i, par_stick: par_stick_i};

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk_i (clk_i), .rst_ni (rst_ni), .div_i (div), .tick_o (tick)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr_i), .wdata_i (wdata_i),
    .take_i (take), .full_o (hold_full), .data_o (hold_data)
  );

  uart_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .TCNT_W(TCNT_W)) u_frame (
    .data_i (hold_data), .cfg_i (cfg), .bits_o (frame_bits), .last_tick_o (last_tick)
  );

  assign start_ok = hold_full && (!afc_en_i || cts_i);

  uart_tx_shift #(.FRAME_W(FRAME_W), .TCNT_W(TCNT_W)) u_shift (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick), .start_ok_i (start_ok),
    .bits_i (frame_bits), .last_tick_i (last_tick), .take_o (take),
    .busy_o (busy), .line_o (line)
  );

  assign tx_o         = brk_i ? 1'b0 : ((div == '0) ? 1'b1 : line);
  assign hold_empty_o = !hold_full;
  assign tx_empty_o   = !hold_full && !busy;
endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] div_hi = 8'd0, div_lo = 8'd0;
  logic [1:0] wlen = 2'd3;
  logic       stop2 = 0, par_en = 0, par_even = 0, par_stick = 0;
  logic       brk = 0, afc_en = 0, cts = 0, wr = 0;
  logic [7:0] wdata = 8'd0;
  logic       tx, hold_empty, tx_empty;

  int    checks = 0, failures = 0, cyc = 0;
  string cur_req = "R10";
  bit    finished = 0;

  always #5 clk = ~clk;

  uart_tx_core dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .div_hi_i (div_hi), .div_lo_i (div_lo),
    .wlen_i (wlen), .stop2_i (stop2), .par_en_i (par_en), .par_even_i (par_even),
    .par_stick_i (par_stick), .brk_i (brk), .afc_en_i (afc_en), .cts_i (cts),
    .wr_i (wr), .wdata_i (wdata), .tx_o (tx), .hold_empty_o (hold_empty),
    .tx_empty_o (tx_empty)
  );

  // reference model: line level per bit-clock tick kept in a queue
  int         m_cnt;
  bit         m_busy, m_full;
  logic [7:0] m_data;
  bit         m_line[$];

  task automatic build_frame(input logic [7:0] d);
    int n, ones, stop_t;
    bit p;
    n = 5 + int'(wlen);
    ones = 0;
    m_line.delete();
    repeat (16) m_line.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      repeat (16) m_line.push_back(d[i]);
      if (d[i]) ones++;
    end
    if (par_en) begin
      if (par_stick) p = !par_even;
      else if (par_even) p = (ones % 2) == 1;
      else p = (ones % 2) == 0;
      repeat (16) m_line.push_back(p);
    end
    stop_t = !stop2 ? 16 : (n == 5 ? 24 : 32);
    repeat (stop_t) m_line.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = 0; m_busy = 0; m_full = 0; m_data = 0; m_line.delete();
    end else begin
      int  dv;
      bit  tk, ld, was_full;
      dv = {div_hi, div_lo};
      tk = (dv != 0) && (m_cnt >= dv - 1);
      m_cnt = (dv == 0 || tk) ? 0 : m_cnt + 1;
      ld = 0;
      was_full = m_full;
      if (tk) begin
        if (m_busy) begin
          void'(m_line.pop_front());
          if (m_line.size() == 0) m_busy = 0;
        end
        if (!m_busy && m_full && (!afc_en || cts)) begin
          build_frame(m_data);
          m_busy = 1; ld = 1;
        end
      end
      if (wr && (!was_full || ld)) begin m_full = 1; m_data = wdata; end
      else if (ld) m_full = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      logic ex_tx;
      int   dv;
      dv = {div_hi, div_lo};
      ex_tx = brk ? 1'b0 : (dv == 0 ? 1'b1 : (m_busy ? m_line[0] : 1'b1));
      check(cur_req, tx, ex_tx, "tx_o");
      check(cur_req, hold_empty, !m_full, "hold_empty_o");
      check(cur_req, tx_empty, !m_full && !m_busy, "tx_empty_o");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog %s actual=running expected=done", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_raw(input logic [7:0] b);
    @(posedge clk); #1;
    wr = 1; wdata = b;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    while (!hold_empty) begin @(posedge clk); #1; end
    wr_raw(b);
  endtask

  task automatic wait_empty(input int limit);
    int n;
    n = 0;
    while (!tx_empty && n < limit) begin @(posedge clk); #1; n++; end
  endtask

  initial begin
    cycles(5);
    @(negedge clk);
    cur_req = "R10";
    check("R10", tx, 1'b1, "tx_o after reset");
    check("R10", hold_empty, 1'b1, "hold_empty_o after reset");
    check("R10", tx_empty, 1'b1, "tx_empty_o after reset");
    @(posedge clk); #1;
    rst_ni = 1;

    cur_req = "R5";
    wr_raw(8'hA5);
    cycles(100);
    @(negedge clk);
    check("R5", hold_empty, 1'b0, "byte held with zero divisor");
    check("R5", tx, 1'b1, "line idle with zero divisor");
    @(posedge clk); #1;

    cur_req = "R1 R2";
    div_lo = 8'd2; wlen = 2'd3;
    wait_empty(2000);

    cur_req = "R3 R4 R11";
    wlen = 2'd0; par_en = 1; par_even = 1; stop2 = 1;
    wr_byte(8'h13);
    wr_byte(8'h0C);
    wait_empty(4000);

    cur_req = "R4";
    wlen = 2'd2; par_even = 0;
    wr_byte(8'h7F);
    wait_empty(2000);

    cur_req = "R3";
    wlen = 2'd1; par_stick = 1; par_even = 0;
    wr_byte(8'h2A);
    wait_empty(2000);
    par_even = 1;
    wr_byte(8'h15);
    wait_empty(2000);

    cur_req = "R7";
    par_stick = 0; par_en = 0; stop2 = 0; wlen = 2'd3;
    afc_en = 1; cts = 0;
    wr_byte(8'h5A);
    cycles(300);
    @(negedge clk);
    check("R7", tx, 1'b1, "no start without cts");
    check("R7", hold_empty, 1'b0, "byte waits for cts");
    @(posedge clk); #1;
    cts = 1;
    cycles(40);
    cts = 0;
    wait_empty(2000);
    @(negedge clk);
    check("R7", tx_empty, 1'b1, "frame finished after cts fell");
    @(posedge clk); #1;

    cur_req = "R6";
    afc_en = 0;
    wr_byte(8'hFF);
    cycles(50);
    brk = 1;
    cycles(60);
    @(negedge clk);
    check("R6", tx, 1'b0, "break holds line low");
    @(posedge clk); #1;
    brk = 0;
    wait_empty(2000);

    cur_req = "R8 R9";
    wr_byte(8'h3C);
    wr_byte(8'hB4);
    wr_raw(8'hE1);
    @(negedge clk);
    check("R8", hold_empty, 1'b0, "register still full after drop");
    @(posedge clk); #1;
    wait_empty(4000);

    cur_req = "R9";
    wr_byte(8'hC3);
    cycles(30);
    wlen = 2'd0; par_en = 1; stop2 = 1;
    wait_empty(2000);
    wlen = 2'd0; par_en = 0; stop2 = 0;

    cur_req = "R1";
    div_hi = 8'd1; div_lo = 8'd0;
    wr_byte(8'h11);
    wait_empty(40000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule